// File: doc/BRIEF.md
# Backplane JTAG Slot Selector

This block lets many boards share one test bus on a backplane and still be reached one at a time. The bus master selects boards with ordinary JTAG instructions. No extra select lines are needed. Each gateway reads a slot number from its strap pins. When the instruction register value is written at Update-IR, the gateway compares the low six bits with that slot number and decides whether it should join the bus.

Besides selecting one board, the master can select every board at once. It can also select one of four groups. Each board's group comes from a small group register that the master loads beforehand. Only a board selected alone drives its test data output, and only while data is shifting. In the other selection modes every output stays in high impedance, so boards never drive the bus against each other. A board whose address does not match is locked out until it is sent back to the waiting state.

The TAP controller and the instruction and data shift paths sit outside this block. They provide the Update-IR and Update-DR strobes, the Test-Logic-Reset indication, the shift indication and the parallel register values.

Top module: `jtag_drop_select`

## Requirements
- R1: While `trst_n` is low the block is waiting and unselected: `sel`=0, `sel_n`=1, `lsp_en_n`=1, `tdo_oe`=0, and the group register is 0.
- R2: At an Update-IR strobe while waiting, the block takes only `ir[5:0]` as an address and ignores `ir[7:6]`. If the address equals `slot` and `slot` is below 58, the block becomes single-selected from the next rising edge. Whenever it is selected, `sel`=1 and `sel_n`=`lsp_en_n`=0.
- R3: In any other case of R2 that R4 and R5 do not cover, the block becomes unselected. Every later Update-IR value except 0xC3 leaves it unselected, including an address that matches.
- R4: Address 0x3B selects the block in broadcast mode.
- R5: Addresses 0x3C to 0x3F select the block in group mode only when (address - 0x3C) equals the group register. Any other group value makes the block unselected.
- R6: The group register takes `dr_grp` at an Update-DR strobe, but only while the block is single-selected with 0x03 as its current instruction. The current instruction is the last Update-IR value received while selected, and it is 0xFF right after selection.
- R7: A cycle with `tlr` high returns the block to waiting and clears the group register. Asserting `trst_n` low also clears the group register.
- R8: Instruction 0xC3 at Update-IR returns a selected or unselected block to waiting.
- R9: While `lsp_rst_n` is low the block is waiting. `lsp_trst_n` is low whenever `lsp_rst_n` or `trst_n` is low. The group register keeps its value through this reset.
- R10: `tdo_oe` is set only on a falling edge of `tck` that finds the block single-selected and `shift` high. It stays 0 in broadcast and group mode.
- R11: A slot strapped to a reserved value (58 to 63) never gives a single selection. Writing 0x3A to such a board leaves it unselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Primary test reset, active low, asynchronous |
| lsp_rst_n | input | 1 | Local port reset input, active low, asynchronous |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| upd_ir | input | 1 | Update-IR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| shift | input | 1 | TAP is in Shift-IR or Shift-DR |
| ir | input | 8 | Instruction register parallel value |
| dr_grp | input | 2 | Group value from the data shift path |
| slot | input | 6 | Strapped slot address |
| sel | output | 1 | Block is selected |
| sel_n | output | 1 | Selected, active low |
| lsp_en_n | output | 1 | Local port enable, active low |
| tdo_oe | output | 1 | Test data output enable |
| lsp_trst_n | output | 1 | Reset to the local scan ports, active low |

## Verification
If the selection state is wrong, `sel`, `sel_n` and `lsp_en_n` show it at the rising edge that follows the Update-IR strobe. A wrong output enable shows half a cycle later, at the next falling edge. A wrong group register never shows directly. It appears only when a later group address selects the board or fails to, so every group load is followed by a group address and compared against what the bench expects. The lock-out is tested by writing a matching address to an unselected board and checking that nothing changes.

// File: rtl/jds_pkg.sv
package jds_pkg;
  typedef enum logic [2:0] {ST_WAIT, ST_UNSEL, ST_SINGLE, ST_BCAST, ST_GROUP} sel_state_e;
  typedef enum logic [1:0] {K_NONE, K_SINGLE, K_BCAST, K_GROUP} match_e;
endpackage

// File: rtl/jds_addr_match.sv
module jds_addr_match import jds_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int GRP_W  = 2
) (
  input  logic [ADDR_W-1:0] code,
  input  logic [ADDR_W-1:0] slot,
  input  logic [GRP_W-1:0]  grp,
  output match_e            kind
);
  // group codes take the top 2^GRP_W addresses, broadcast sits just below
  localparam logic [ADDR_W-1:0] GRP_BASE = ADDR_W'(((1 << ADDR_W) - 1) ^ ((1 << GRP_W) - 1));
  localparam logic [ADDR_W-1:0] BCAST    = GRP_BASE - 1'b1;
  localparam logic [ADDR_W-1:0] RESV_LO  = GRP_BASE - 2'd2;

  function automatic match_e classify(input logic [ADDR_W-1:0] c,
                                      input logic [ADDR_W-1:0] s,
                                      input logic [GRP_W-1:0]  g);
    if (c == BCAST)         return K_BCAST;
    if (c >= GRP_BASE)      return (c[GRP_W-1:0] == g) ? K_GROUP : K_NONE;
    if (c == s && s < RESV_LO) return K_SINGLE;
    return K_NONE;
  endfunction

  assign kind = classify(code, slot, grp);
endmodule

// File: rtl/jds_sel_fsm.sv
module jds_sel_fsm import jds_pkg::*; #(
  parameter int               IR_W    = 8,
  parameter logic [IR_W-1:0]  GOTO_OP = 8'hC3
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tlr,
  input  logic            upd_ir,
  input  logic [IR_W-1:0] ir,
  input  match_e          kind,
  output sel_state_e      state,
  output logic [IR_W-1:0] cur_op
);
  localparam logic [IR_W-1:0] IDLE_OP = '1;

  sel_state_e nxt;
  logic [IR_W-1:0] nxt_op;

  always_comb begin
    nxt    = state;
    nxt_op = cur_op;
    if (tlr) begin
      nxt    = ST_WAIT;
      nxt_op = IDLE_OP;
    end else if (upd_ir) begin
      unique case (state)
        ST_WAIT: begin
          nxt_op = IDLE_OP;
          unique case (kind)
            K_SINGLE: nxt = ST_SINGLE;
            K_BCAST:  nxt = ST_BCAST;
            K_GROUP:  nxt = ST_GROUP;
            default:  nxt = ST_UNSEL;
          endcase
        end
        ST_UNSEL: if (ir == GOTO_OP) nxt = ST_WAIT;
        default: begin
          if (ir == GOTO_OP) begin
            nxt    = ST_WAIT;
            nxt_op = IDLE_OP;
          end else begin
            nxt_op = ir;
          end
        end
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_WAIT;
      cur_op <= IDLE_OP;
    end else begin
      state  <= nxt;
      cur_op <= nxt_op;
    end
  end
endmodule

// File: rtl/jds_grp_reg.sv
module jds_grp_reg #(
  parameter int GRP_W = 2
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tlr,
  input  logic             load,
  input  logic [GRP_W-1:0] d,
  output logic [GRP_W-1:0] q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)   q <= '0;
    else if (tlr)  q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/jds_oe.sv
module jds_oe (
  input  logic tck,
  input  logic rst_n,
  input  logic single,
  input  logic shift,
  output logic oe
);
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) oe <= 1'b0;
    else        oe <= single & shift;
  end
endmodule

// File: rtl/jtag_drop_select.sv
module jtag_drop_select import jds_pkg::*; #(
  parameter int              IR_W    = 8,
  parameter int              ADDR_W  = 6,
  parameter int              GRP_W   = 2,
  parameter logic [IR_W-1:0] GOTO_OP = 8'hC3,
  parameter logic [IR_W-1:0] GRP_OP  = 8'h03
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              lsp_rst_n,
  input  logic              tlr,
  input  logic              upd_ir,
  input  logic              upd_dr,
  input  logic              shift,
  input  logic [IR_W-1:0]   ir,
  input  logic [GRP_W-1:0]  dr_grp,
  input  logic [ADDR_W-1:0] slot,
  output logic              sel,
  output logic              sel_n,
  output logic              lsp_en_n,
  output logic              tdo_oe,
  output logic              lsp_trst_n
);
  logic            rst_n;
  match_e          kind;
  sel_state_e      state;
  logic [IR_W-1:0] cur_op;
  logic [GRP_W-1:0] grp_q;
  logic            grp_load;
  logic            st_wait, st_unsel, st_single;

  assign rst_n = trst_n & lsp_rst_n;

  jds_addr_match #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_match (
    .code(ir[ADDR_W-1:0]), .slot(slot), .grp(grp_q), .kind(kind));

  jds_sel_fsm #(.IR_W(IR_W), .GOTO_OP(GOTO_OP)) u_fsm (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .upd_ir(upd_ir), .ir(ir),
    .kind(kind), .state(state), .cur_op(cur_op));

  assign st_wait   = (state == ST_WAIT);
  assign st_unsel  = (state == ST_UNSEL);
  assign st_single = (state == ST_SINGLE);
  assign grp_load  = st_single & upd_dr & (cur_op == GRP_OP);

  jds_grp_reg #(.GRP_W(GRP_W)) u_grp (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .load(grp_load), .d(dr_grp), .q(grp_q));

  jds_oe u_oe (.tck(tck), .rst_n(rst_n), .single(st_single), .shift(shift), .oe(tdo_oe));

  assign sel        = ~(st_wait | st_unsel);
  assign sel_n      = ~sel;
  assign lsp_en_n   = ~sel;
  assign lsp_trst_n = rst_n;
endmodule

// File: rtl/jds_chk.sv
module jds_chk #(
  parameter int IR_W   = 8,
  parameter int ADDR_W = 6,
  parameter int GRP_W  = 2
) (
  input logic              tck,
  input logic              rst_n,
  input logic              tlr,
  input logic              upd_ir,
  input logic [IR_W-1:0]   ir,
  input logic [ADDR_W-1:0] slot,
  input logic              sel,
  input logic              tdo_oe,
  input logic              st_wait,
  input logic              st_unsel,
  input logic [GRP_W-1:0]  grp_q
);
  localparam logic [ADDR_W-1:0] GRP_BASE = ADDR_W'(((1 << ADDR_W) - 1) ^ ((1 << GRP_W) - 1));
  localparam logic [ADDR_W-1:0] BCAST    = GRP_BASE - 1'b1;
  localparam logic [ADDR_W-1:0] RESV_LO  = GRP_BASE - 2'd2;
  localparam logic [IR_W-1:0]   GOTO     = 8'hC3;

  AST_MATCH_SELECTS: assert property (@(posedge tck) disable iff (!rst_n)
    (st_wait && upd_ir && !tlr && ir[ADDR_W-1:0] == slot && slot < RESV_LO) |=> sel); // R2
  AST_LOCKOUT_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
    (st_unsel && upd_ir && !tlr && ir != GOTO) |=> !sel); // R3
  AST_BCAST_SELECTS: assert property (@(posedge tck) disable iff (!rst_n)
    (st_wait && upd_ir && !tlr && ir[ADDR_W-1:0] == BCAST) |=> sel); // R4
  AST_TLR_CLEARS: assert property (@(posedge tck) disable iff (!rst_n)
    tlr |=> (grp_q == '0 && !sel)); // R7
  AST_GOTO_WAITS: assert property (@(posedge tck) disable iff (!rst_n)
    (upd_ir && !tlr && ir == GOTO && !st_wait) |=> st_wait); // R8
  AST_OE_NEEDS_SEL: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> sel); // R10
endmodule

bind jtag_drop_select jds_chk #(.IR_W(IR_W), .ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .tlr(tlr), .upd_ir(upd_ir), .ir(ir), .slot(slot),
  .sel(sel), .tdo_oe(tdo_oe), .st_wait(st_wait), .st_unsel(st_unsel), .grp_q(grp_q));

// File: tb/test_jtag_drop_select.sv
`timescale 1ns/1ps
module test_jtag_drop_select;
  logic tck = 1'b0;
  always #10 tck = ~tck;

  logic trst_n = 1'b0, lsp_rst_n = 1'b1, tlr = 1'b0, upd_ir = 1'b0, upd_dr = 1'b0, shift = 1'b0;
  logic [7:0] ir = 8'h00;
  logic [1:0] dr_grp = 2'd0;
  logic [5:0] slot = 6'd5;
  logic sel, sel_n, lsp_en_n, tdo_oe, lsp_trst_n;

  jtag_drop_select i_jtag_drop_select (
    .tck(tck), .trst_n(trst_n), .lsp_rst_n(lsp_rst_n), .tlr(tlr), .upd_ir(upd_ir),
    .upd_dr(upd_dr), .shift(shift), .ir(ir), .dr_grp(dr_grp), .slot(slot),
    .sel(sel), .sel_n(sel_n), .lsp_en_n(lsp_en_n), .tdo_oe(tdo_oe), .lsp_trst_n(lsp_trst_n));

  // model: 0 wait, 1 unselected, 2 single, 3 broadcast, 4 group
  int m_st = 0, m_grp = 0, m_op = 255;
  bit m_oe = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string req = "R1";

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int old_st, old_op, old_grp, code;
    old_st = m_st; old_op = m_op; old_grp = m_grp;
    if (!trst_n) begin m_st = 0; m_grp = 0; m_op = 255; end
    else if (!lsp_rst_n) begin m_st = 0; m_op = 255; end
    else if (tlr) begin m_st = 0; m_grp = 0; m_op = 255; end
    else begin
      if (upd_ir) begin
        code = int'(ir) % 64;
        if (old_st == 0) begin
          m_op = 255;
          if (code == 59) m_st = 3;
          else if (code >= 60) m_st = (code - 60 == old_grp) ? 4 : 1;
          else if (code == int'(slot) && int'(slot) < 58) m_st = 2;
          else m_st = 1;
        end else if (old_st == 1) begin
          if (ir == 8'hC3) m_st = 0;
        end else begin
          if (ir == 8'hC3) begin m_st = 0; m_op = 255; end
          else m_op = int'(ir);
        end
      end
      if (upd_dr && old_st == 2 && old_op == 3) m_grp = int'(dr_grp);
    end
  endtask

  task automatic tick();
    bit exp_sel;
    @(posedge tck);
    model_edge();
    #10;
    m_oe = (trst_n && lsp_rst_n) ? (m_st == 2 && shift) : 1'b0;
    #5;
    exp_sel = (m_st >= 2);
    chk("sel", int'(sel), int'(exp_sel));
    chk("sel_n", int'(sel_n), int'(!exp_sel));
    chk("lsp_en_n", int'(lsp_en_n), int'(!exp_sel));
    chk("tdo_oe", int'(tdo_oe), int'(m_oe));
    chk("lsp_trst_n", int'(lsp_trst_n), int'(trst_n && lsp_rst_n));
  endtask

  task automatic wr_ir(logic [7:0] v);
    upd_ir = 1'b1; ir = v; tick(); upd_ir = 1'b0;
  endtask

  task automatic wr_dr(logic [1:0] v);
    upd_dr = 1'b1; dr_grp = v; tick(); upd_dr = 1'b0;
  endtask

  task automatic do_tlr();
    tlr = 1'b1; tick(); tlr = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #3;
    req = "R1"; tick(); tick();
    trst_n = 1'b1; tick();
    // R2: upper IR bits ignored, slot 5 matches
    req = "R2"; wr_ir(8'hC5); tick();
    req = "R10"; shift = 1'b1; tick(); tick(); shift = 1'b0; tick();
    // R6: load group 2 while single-selected
    req = "R6"; wr_ir(8'h03); wr_dr(2'd2);
    req = "R8"; wr_ir(8'hC3); tick();
    req = "R5"; wr_ir(8'h3E); shift = 1'b1; tick(); shift = 1'b0;
    req = "R8"; wr_ir(8'hC3);
    req = "R5"; wr_ir(8'h3D); tick();
    // R3: lock-out ignores even the matching address
    req = "R3"; wr_ir(8'h05); wr_ir(8'h3B); tick();
    req = "R8"; wr_ir(8'hC3); tick();
    req = "R4"; wr_ir(8'h3B); shift = 1'b1; tick(); shift = 1'b0;
    // R7: TLR returns to waiting and clears group
    req = "R7"; do_tlr(); wr_ir(8'h3C); tick(); do_tlr();
    // R9: local reset keeps group 1
    req = "R9"; wr_ir(8'h45); wr_ir(8'h03); wr_dr(2'd1);
    lsp_rst_n = 1'b0; tick(); tick(); lsp_rst_n = 1'b1; tick();
    wr_ir(8'h3D); tick(); wr_ir(8'hC3);
    // R7: TRST clears group
    req = "R7"; trst_n = 1'b0; tick(); trst_n = 1'b1; tick();
    wr_ir(8'h3D); do_tlr();
    // R6 negative: group load ignored in broadcast mode
    req = "R6"; wr_ir(8'h3B); wr_ir(8'h03); wr_dr(2'd3); wr_ir(8'hC3);
    wr_ir(8'h3F); tick(); wr_ir(8'hC3); wr_ir(8'h3C); tick(); do_tlr();
    // R11: reserved slot never single-selects
    req = "R11"; slot = 6'd58; tick(); wr_ir(8'h3A); tick(); do_tlr();
    req = "R2"; slot = 6'd0; tick(); wr_ir(8'h80); shift = 1'b1; tick(); shift = 1'b0; do_tlr();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule